// File: doc/BRIEF.md
# Tokenized In-Order Completion Buffer

This block lets a pipeline start work out of order-insensitive order and still hand results downstream in the order the work started. A requester asks for a token and gets the next sequence number. The token travels with its job. When the job finishes, perhaps long after jobs that started later, its result is written back against that token. The buffer then releases results strictly in the order the tokens were handed out. A result that finishes early waits until every older result has been released.

The storage is a ring of slots, and each slot has a filled flag. A write pointer gives out tokens and a read pointer marks the oldest outstanding slot. An occupancy counter tracks how many tokens are outstanding. A token can be granted only while a free slot exists. A result can leave only when at least one token is outstanding and the oldest slot has been filled. Writes that name a slot with no outstanding token are dropped.

Top module: `cbuf_top`

## Requirements
- R1: After a synchronous active-low reset, `tok_avail` is 1, `tok_id` is 0 and `res_vld` is 0.
- R2: Each granted token (a cycle with `tok_req` and `tok_avail` both high) takes the value shown on `tok_id` in that cycle. Successive grants count up by one and wrap from DEPTH-1 to 0.
- R3: Once DEPTH tokens are outstanding, `tok_avail` is 0 and `tok_req` grants nothing.
- R4: A write (`put_vld`) stores `put_data` in the slot named by `put_tok`. `res_vld` stays 0 while the oldest outstanding slot is unfilled, even when younger slots are filled.
- R5: Results are released in token order whatever the order of the writes. Each release (`res_vld` and `res_rdy` high) presents the oldest slot's data on `res_data` and advances to the next token.
- R6: A grant and a release in the same cycle leave the number of outstanding tokens unchanged.
- R7: A write to a slot that holds no outstanding token is ignored. This includes a write to the token being granted in that same cycle: that slot stays unfilled.
- R8: Granting a token clears the slot's filled flag, so stale data left from an earlier use of that slot is never released.
- R9: `res_vld` is 0 whenever no token is outstanding, even if the slot under the read pointer still holds old data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tok_req | input | 1 | Request for a new token |
| tok_avail | output | 1 | A free slot exists; a request this cycle is granted |
| tok_id | output | TOK_W | Token granted when a request is accepted |
| put_vld | input | 1 | Write a completed result |
| put_tok | input | TOK_W | Token the result belongs to |
| put_data | input | DATA_W | Result value |
| res_vld | output | 1 | Oldest outstanding slot is filled and can be released |
| res_data | output | DATA_W | Data of the oldest outstanding slot |
| res_rdy | input | 1 | Consumer takes the result this cycle |

## Verification
Two situations are hard to reach from the ports. The first is a grant and a release in the same cycle while the ring is nearly full. The bench reaches it by filling every slot, draining one, and then raising a request and an acceptance together. The next grant must then fill the ring exactly. The second is a stale write that lands on a slot in the cycle that slot is granted again. The bench drives a write to the slot named on `tok_id` while it raises `tok_req`. It also leaves old filled flags behind in the ring so that a slot reused without clearing would show up as a premature `res_vld`.

// File: rtl/cbuf_pkg.sv
// Package: shared defaults and the per-cycle event bundle of the completion buffer.
package cbuf_pkg;
    localparam int CB_DEPTH_DEF  = 8;
    localparam int CB_DATA_W_DEF = 16;

    // Handshake events that fire on a clock edge
    typedef struct packed {
        logic grant;
        logic pop;
    } cb_evt_t;
endpackage

// File: rtl/cbuf_ptrs.sv
// Module: cbuf_ptrs
// Holds the write index, read index and occupancy count of the ring.
// Assumes DEPTH is a power of two, so the indices wrap by overflow.
// The caller only raises evt.pop while at least one slot is occupied.
module cbuf_ptrs
    import cbuf_pkg::*;
#(
    parameter int DEPTH = CB_DEPTH_DEF,
    localparam int TOK_W = $clog2(DEPTH),
    localparam int CNT_W = TOK_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_req,
    input  logic             pop,
    output cb_evt_t          evt,
    output logic [TOK_W-1:0] wr_idx,
    output logic [TOK_W-1:0] rd_idx,
    output logic [CNT_W-1:0] cnt,
    output logic             tok_avail
);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    // Decode space availability and the events of this cycle
    always_comb begin
        tok_avail = (cnt != FULL);
        evt.grant = tok_req && tok_avail;
        evt.pop   = pop;
    end

    // Advance the write index on every grant
    always_ff @(posedge clk) begin
        if (!rst_n)         wr_idx <= '0;
        else if (evt.grant) wr_idx <= wr_idx + 1'b1;
    end

    // Advance the read index on every release
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_idx <= '0;
        else if (evt.pop) rd_idx <= rd_idx + 1'b1;
    end

    // Track the number of outstanding tokens
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else begin
            case ({evt.grant, evt.pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL);
    // R2
    tok_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.grant |=> wr_idx == TOK_W'($past(wr_idx) + 1'b1));
    // R5
    rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt.pop |=> rd_idx == TOK_W'($past(rd_idx) + 1'b1));
    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt.grant && evt.pop) |=> $stable(cnt));
endmodule

// File: rtl/cbuf_slots.sv
// Module: cbuf_slots
// Ring of data slots, each with a filled flag.
// A grant clears the flag of the granted slot, and an accepted write sets it.
// Assumes put_ok is already qualified, so it is high only for an outstanding token.
module cbuf_slots #(
    parameter int DEPTH  = 8,
    parameter int DATA_W = 16,
    localparam int TOK_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant,
    input  logic [TOK_W-1:0]  wr_idx,
    input  logic              put_vld,
    input  logic              put_ok,
    input  logic [TOK_W-1:0]  put_tok,
    input  logic [DATA_W-1:0] put_data,
    input  logic [TOK_W-1:0]  rd_idx,
    output logic              head_full,
    output logic [DATA_W-1:0] head_data
);
    logic [DEPTH-1:0]  full_q;
    logic [DATA_W-1:0] data_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        // Clear the flag on grant and set it on an accepted write
        always_ff @(posedge clk) begin
            if (!rst_n)
                full_q[s] <= 1'b0;
            else if (grant && wr_idx == TOK_W'(s))
                full_q[s] <= 1'b0;
            else if (put_ok && put_tok == TOK_W'(s))
                full_q[s] <= 1'b1;
        end

        // Capture the result data of an accepted write
        always_ff @(posedge clk) begin
            if (!rst_n)
                data_q[s] <= '0;
            else if (put_ok && put_tok == TOK_W'(s))
                data_q[s] <= put_data;
        end
    end

    // Present the oldest slot
    always_comb begin
        head_full = full_q[rd_idx];
        head_data = data_q[rd_idx];
    end

    // R8
    regrant_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !full_q[$past(wr_idx)]);
    // R7
    stray_put_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (put_vld && !put_ok && !grant) |=> $stable(full_q));
    // R4
    put_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        put_ok |=> full_q[$past(put_tok)]);
endmodule

// File: rtl/cbuf_top.sv
// Module: cbuf_top
// Tokenized in-order completion buffer. It hands out sequential tokens,
// accepts results against them in any order, and releases the results
// strictly in token order. Assumes DEPTH is a power of two.
module cbuf_top
    import cbuf_pkg::*;
#(
    parameter int DEPTH  = CB_DEPTH_DEF,
    parameter int DATA_W = CB_DATA_W_DEF,
    localparam int TOK_W = $clog2(DEPTH),
    localparam int CNT_W = TOK_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_req,
    output logic              tok_avail,
    output logic [TOK_W-1:0]  tok_id,
    input  logic              put_vld,
    input  logic [TOK_W-1:0]  put_tok,
    input  logic [DATA_W-1:0] put_data,
    output logic              res_vld,
    output logic [DATA_W-1:0] res_data,
    input  logic              res_rdy
);
    cb_evt_t          evt;
    logic [TOK_W-1:0] wr_idx;
    logic [TOK_W-1:0] rd_idx;
    logic [CNT_W-1:0] cnt;
    logic [TOK_W-1:0] put_age;
    logic             put_ok;
    logic             head_full;
    logic             pop;

    // A write is accepted only when its token lies inside the outstanding window
    always_comb begin
        put_age = put_tok - rd_idx;
        put_ok  = put_vld && ({1'b0, put_age} < cnt);
    end

    // Release needs an outstanding token whose slot is filled
    always_comb begin
        res_vld = (cnt != '0) && head_full;
        pop     = res_vld && res_rdy;
        tok_id  = wr_idx;
    end

    cbuf_ptrs #(.DEPTH(DEPTH)) i_ptrs (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_req   (tok_req),
        .pop       (pop),
        .evt       (evt),
        .wr_idx    (wr_idx),
        .rd_idx    (rd_idx),
        .cnt       (cnt),
        .tok_avail (tok_avail)
    );

    cbuf_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant     (evt.grant),
        .wr_idx    (wr_idx),
        .put_vld   (put_vld),
        .put_ok    (put_ok),
        .put_tok   (put_tok),
        .put_data  (put_data),
        .rd_idx    (rd_idx),
        .head_full (head_full),
        .head_data (res_data)
    );

    // R9
    empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && cnt == CNT_W'(1) && !evt.grant) |=> !res_vld);
endmodule

// File: tb/test_cbuf_top.sv
`timescale 1ns/1ps
// Bench for cbuf_top: a table of write orders with the release counts each
// write should unlock, followed by directed tests for reset, full, reuse and
// same-cycle corner cases.
module test_cbuf_top;
    localparam int DEPTH  = 8;
    localparam int DATA_W = 16;
    localparam int TOK_W  = 3;

    // Write order and the number of releases each write unlocks
    localparam int ORDER   [8] = '{3, 1, 0, 2, 7, 5, 6, 4};
    localparam int EXP_REL [8] = '{0, 0, 2, 2, 0, 0, 0, 4};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tok_req = 1'b0;
    logic              tok_avail;
    logic [TOK_W-1:0]  tok_id;
    logic              put_vld = 1'b0;
    logic [TOK_W-1:0]  put_tok = '0;
    logic [DATA_W-1:0] put_data = '0;
    logic              res_vld;
    logic [DATA_W-1:0] res_data;
    logic              res_rdy = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;

    cbuf_top #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_cbuf_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .tok_req   (tok_req),
        .tok_avail (tok_avail),
        .tok_id    (tok_id),
        .put_vld   (put_vld),
        .put_tok   (put_tok),
        .put_data  (put_data),
        .res_vld   (res_vld),
        .res_data  (res_data),
        .res_rdy   (res_rdy)
    );

    always #10 clk = ~clk;

    function automatic logic [DATA_W-1:0] val_of(int t);
        return DATA_W'(16'hA000 + t * 16'h0011);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Let one edge pass, then drop all strobes and let outputs settle
    task automatic tick();
        @(posedge clk);
        #2;
        tok_req = 1'b0;
        put_vld = 1'b0;
        res_rdy = 1'b0;
        #1;
    endtask

    task automatic do_put(input int t, input logic [DATA_W-1:0] d);
        put_vld  = 1'b1;
        put_tok  = TOK_W'(t);
        put_data = d;
        tick();
    endtask

    task automatic release_one(input int t, input string req);
        chk(res_vld === 1'b1, req, int'(res_vld), 1);
        chk(res_data === val_of(t), req, int'(res_data), int'(val_of(t)));
        res_rdy = 1'b1;
        tick();
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int head;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;

        // R1 reset state
        chk(tok_avail === 1'b1, "R1", int'(tok_avail), 1);
        chk(tok_id === 3'd0, "R1", int'(tok_id), 0);
        chk(res_vld === 1'b0, "R1", int'(res_vld), 0);

        // R2 sequential tokens, fill to capacity
        for (int i = 0; i < DEPTH; i++) begin
            chk(tok_id === TOK_W'(i), "R2", int'(tok_id), i);
            tok_req = 1'b1;
            tick();
        end
        // R3 full: no availability and a request grants nothing
        chk(tok_avail === 1'b0, "R3", int'(tok_avail), 0);
        tok_req = 1'b1;
        tick();
        chk(tok_avail === 1'b0, "R3", int'(tok_avail), 0);
        chk(tok_id === 3'd0, "R3", int'(tok_id), 0);
        chk(res_vld === 1'b0, "R4", int'(res_vld), 0);

        // R4 R5 table of out-of-order writes with in-order release
        head = 0;
        for (int k = 0; k < DEPTH; k++) begin
            do_put(ORDER[k], val_of(ORDER[k]));
            for (int r = 0; r < EXP_REL[k]; r++) begin
                release_one(head, "R5");
                head++;
            end
            chk(res_vld === 1'b0, "R4", int'(res_vld), 0);
        end
        // R9 empty with old filled flags behind the read pointer
        chk(res_vld === 1'b0, "R9", int'(res_vld), 0);
        chk(tok_avail === 1'b1, "R9", int'(tok_avail), 1);

        // R7 write to the token being granted in the same cycle is dropped
        chk(tok_id === 3'd0, "R2", int'(tok_id), 0);
        tok_req  = 1'b1;
        put_vld  = 1'b1;
        put_tok  = tok_id;
        put_data = 16'hDEAD;
        tick();
        chk(res_vld === 1'b0, "R7", int'(res_vld), 0);

        // R8 slot 1 holds an old filled flag; re-granting must clear it
        tok_req = 1'b1;
        tick();
        do_put(0, val_of(0));
        release_one(0, "R7");
        chk(res_vld === 1'b0, "R8", int'(res_vld), 0);
        do_put(1, val_of(1));
        release_one(1, "R8");

        // R2 wrap: grant eight tokens starting at 2
        for (int i = 0; i < DEPTH; i++) begin
            chk(tok_id === TOK_W'(i + 2), "R2", int'(tok_id), (i + 2) % DEPTH);
            tok_req = 1'b1;
            tick();
        end
        chk(tok_avail === 1'b0, "R3", int'(tok_avail), 0);

        // R6 grant and release together keep occupancy
        do_put(2, val_of(2));
        release_one(2, "R5");
        do_put(3, val_of(3));
        chk(tok_avail === 1'b1, "R6", int'(tok_avail), 1);
        chk(res_vld === 1'b1, "R6", int'(res_vld), 1);
        tok_req = 1'b1;
        res_rdy = 1'b1;
        tick();
        chk(tok_avail === 1'b1, "R6", int'(tok_avail), 1);
        chk(tok_id === 3'd3, "R6", int'(tok_id), 3);
        tok_req = 1'b1;
        tick();
        chk(tok_avail === 1'b0, "R6", int'(tok_avail), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule